// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Interface

This block is the target side of a two-wire serial bus in front of a small byte-wide nonvolatile memory. It oversamples the clock and data lines with a fast system clock and detects Start and Stop conditions. After a Start it checks the first byte against a fixed device type code and three strap pins. It acknowledges the bytes addressed to it by pulling the shared data line low through an open-drain enable. The storage array is not part of the block. It asks a memory back end for each byte with a write request stream and a read request stream.

A write transaction sends the device byte with the direction bit low, then one word address byte, then any number of data bytes. Each data byte goes to the back end at the current pointer, and the pointer advances by one. A Stop that ends a transaction with at least one written byte raises a one-cycle commit pulse. The back end then runs its internal write cycle and holds the busy input high until it finishes. A read fetches from the pointer one byte at a time and advances the pointer after each fetch, wrapping to zero after the last location. A random read is a write transaction carrying only the word address, followed by a repeated Start and a read. A read that starts with no word address continues from wherever the pointer stands.

Back-pressure rules:
- A write request holds its address and data until the back end raises `wr_ready`. The back end must accept it before the next data byte reaches its acknowledge clock.
- A read request holds its address until `rd_ready`. The back end must put the byte on `rd_data` in the cycle where `rd_valid` and `rd_ready` are both high, and it must do so before the next falling SCL edge.

Top module: `eeprom_serial_slave`

## Requirements
- R1: During reset and after it, `sda_oe` is 0, `wr_valid` is 0, `rd_valid` is 0 and `wr_commit` is 0.
- R2: A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high. A Start in any state begins reception of a new device byte, and this includes a repeated Start in the middle of a write. A Stop returns the block to standby.
- R3: Incoming bits are sampled on the rising edge of SCL. `sda_oe` is asserted only while SCL is low, so the data line stays stable during every high phase.
- R4: Bytes are received MSB first. The device byte matches when its bits 7..4 equal 4'b1010 and its bits 3..1 equal `strap_sel`. Bit 0 of the device byte selects the direction, and 1 means read. The block acknowledges by driving the line low for the whole ninth clock and releases the line after that clock.
- R5: On a device byte that does not match, the block gives no acknowledge and goes to standby. It then ignores all bus clocks until the next Start, so it makes no requests and drives no acknowledges.
- R6: While `wr_busy` is high, the block does not acknowledge a device byte, even one that matches.
- R7: In a write, the first byte after the device byte loads the pointer from its low address bits. Each later byte is acknowledged and sent as a write request to the pointer, and the pointer then advances by one.
- R8: Each acknowledged data byte produces exactly one write handshake. `wr_valid`, `wr_addr` and `wr_data` stay unchanged until `wr_ready`.
- R9: After an acknowledged read device byte, the block requests the byte at the pointer and shifts it out MSB first. The pointer advances after each fetched byte and wraps from MEM_BYTES-1 to 0. `rd_valid` and `rd_addr` stay unchanged until `rd_ready`.
- R10: During a read, a master acknowledge (0 on the ninth clock) makes the block fetch and send the next byte. A master no-acknowledge (1 on the ninth clock) makes it release the line and go to standby with no further request.
- R11: `wr_commit` pulses for one cycle right after a detected Stop, and only when at least one data byte was acknowledged since the previous commit.
- R12: In standby the block never drives the data line. After a no-acknowledge or a mismatch, the line reads as released until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_sel | input | 3 | Hardware address straps |
| wr_busy | input | 1 | Back end internal write cycle in progress |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Back end accepts write request |
| wr_addr | output | AW | Write request byte address |
| wr_data | output | 8 | Write request data |
| wr_commit | output | 1 | One-cycle pulse: start the internal write cycle |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Back end answers read request; qualifies rd_data |
| rd_addr | output | AW | Read request byte address |
| rd_data | input | 8 | Read data returned with rd_ready |

## Verification
The assertions assume a well-behaved bus. The master changes SDA only while SCL is low, except for its own Start and Stop conditions. Every SCL phase also lasts long enough for the synchronized samples to settle, and the back end meets the stated answer windows. The stimulus holds each SCL phase for 8 system clocks and moves SDA 4 clocks after a falling edge. The back-end model stalls its ready signals at random, with read answers bounded to 3 cycles, so the hold properties face real back-pressure without breaking the timing windows.

// File: rtl/esl_pkg.sv
package esl_pkg;
  localparam logic [3:0] TYPE_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } esl_state_e;
endpackage

// File: rtl/esl_line_sync.sv
module esl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '1;
      q_prev <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], d};
      q_prev <= chain[STAGES-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/esl_cond_detect.sv
module esl_cond_detect (
  input  logic scl_now,
  input  logic scl_was,
  input  logic sda_now,
  input  logic sda_was,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_held_high;

  assign scl_held_high = scl_now & scl_was;
  assign scl_rise      = scl_now & ~scl_was;
  assign scl_fall      = ~scl_now & scl_was;
  assign start_det     = scl_held_high & sda_was & ~sda_now;
  assign stop_det      = scl_held_high & ~sda_was & sda_now;
endmodule

// File: rtl/esl_ctrl.sv
module esl_ctrl
  import esl_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_lvl,
  input  logic [2:0]    strap_sel,
  input  logic          wr_busy,
  output logic          sda_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output esl_state_e    st_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_CLK  = 4'd9;

  esl_state_e    st;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sh;
  logic [7:0]    tx_sh;
  logic [7:0]    rd_buf;
  logic [AW-1:0] ptr;
  logic          dir_rd;
  logic          wrote;
  logic          addr_hit;

  // device byte compare: type code, straps, and no write cycle running
  assign addr_hit = (rx_sh[7:4] == TYPE_ID) && (rx_sh[3:1] == strap_sel) && !wr_busy;
  assign rd_addr  = ptr;
  assign st_o     = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      rd_buf    <= '1;
      ptr       <= '0;
      dir_rd    <= 1'b0;
      wrote     <= 1'b0;
      sda_oe    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      wr_commit <= 1'b0;

      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        rd_buf   <= rd_data;
        ptr      <= ptr + AW'(1);
      end

      if (stop_det) begin
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
        if (wrote) begin
          wr_commit <= 1'b1;
          wrote     <= 1'b0;
        end
      end else if (start_det) begin
        st      <= ST_DEV;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < LAST_BIT) rx_sh <= {rx_sh[6:0], sda_lvl};
          if (bit_cnt != ACK_CLK) bit_cnt <= bit_cnt + 4'd1;
          // master answer to a byte sent by the block
          if (bit_cnt == LAST_BIT && st == ST_RDATA) begin
            if (sda_lvl) st <= ST_IDLE;
            else         rd_valid <= 1'b1;
          end
        end else if (scl_fall) begin
          if (bit_cnt == LAST_BIT) begin
            // eighth clock over: decide on the acknowledge
            case (st)
              ST_DEV: begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  dir_rd <= rx_sh[0];
                  if (rx_sh[0]) rd_valid <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_WADDR: begin
                sda_oe <= 1'b1;
                ptr    <= rx_sh[AW-1:0];
              end
              ST_WDATA: begin
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= rx_sh;
                ptr      <= ptr + AW'(1);
                wrote    <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bit_cnt == ACK_CLK) begin
            // ninth clock over: release or start the next byte
            bit_cnt <= '0;
            case (st)
              ST_DEV: begin
                if (dir_rd) begin
                  st     <= ST_RDATA;
                  sda_oe <= ~rd_buf[7];
                  tx_sh  <= {rd_buf[6:0], 1'b1};
                end else begin
                  st     <= ST_WADDR;
                  sda_oe <= 1'b0;
                end
              end
              ST_WADDR: begin
                st     <= ST_WDATA;
                sda_oe <= 1'b0;
              end
              ST_RDATA: begin
                sda_oe <= ~rd_buf[7];
                tx_sh  <= {rd_buf[6:0], 1'b1};
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == ST_RDATA && bit_cnt != 4'd0) begin
            sda_oe <= ~tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b1};
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
  import esl_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    strap_sel,
  input  logic          wr_busy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_raw;
  logic [LINES-1:0] line_lvl;
  logic [LINES-1:0] line_prev;
  logic             scl_lvl;
  logic             sda_lvl;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  esl_state_e       ctrl_st;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    esl_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (line_raw[g]),
      .q      (line_lvl[g]),
      .q_prev (line_prev[g])
    );
  end

  assign scl_lvl = line_lvl[0];
  assign sda_lvl = line_lvl[1];

  esl_cond_detect i_cond (
    .scl_now   (scl_lvl),
    .scl_was   (line_prev[0]),
    .sda_now   (sda_lvl),
    .sda_was   (line_prev[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  esl_ctrl #(.AW(AW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .strap_sel (strap_sel),
    .wr_busy   (wr_busy),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .st_o      (ctrl_st)
  );
endmodule

// File: rtl/esl_checker.sv
module esl_checker
  import esl_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          stop_det,
  input logic [2:0]    st,
  input logic          sda_oe,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          wr_commit,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr
);
  // R3: the block starts pulling the line only while SCL is low
  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$stable(sda_oe)) |-> !scl_lvl);

  // R8: a write request holds until the back end takes it
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R9: a read request holds its address until answered
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R11: commit only directly after a detected Stop
  p_commit_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_det));

  // R11: commit is a single-cycle pulse
  p_commit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R12: standby never drives the line
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'(ST_IDLE)) |-> !sda_oe);
endmodule

bind eeprom_serial_slave esl_checker #(.AW(AW)) i_esl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .stop_det  (stop_det),
  .st        (ctrl_st),
  .sda_oe    (sda_oe),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_commit (wr_commit),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr)
);

// File: tb/test_eeprom_serial_slave.sv
module test_eeprom_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int MEM        = 256;
  localparam int AW         = 8;
  localparam int Q          = 4;
  localparam int H          = 8;
  localparam int BUSY_CYC   = 300;
  localparam int WATCHDOG   = 150000;
  localparam logic [2:0] STRAP = 3'b101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl_drv = 1'b1;
  logic          sda_drv = 1'b1;
  logic          sda_line;
  logic          sda_oe;
  logic          wr_busy = 1'b0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          wr_commit;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  logic [7:0] mem   [MEM];
  logic [7:0] model [MEM];
  logic [7:0] wbuf  [8];
  int stg_a [64];
  logic [7:0] stg_d [64];
  int stg_n = 0;
  int n_checks = 0, n_err = 0;
  int wr_hs = 0, rd_hs = 0, commits = 0, unstable = 0;
  int busy_cnt = 0, rd_wait = 0, exp_ptr = 0;
  bit done = 1'b0;

  assign sda_line = sda_drv & ~sda_oe;
  assign rd_data  = mem[rd_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_serial_slave #(.MEM_BYTES(MEM)) i_eeprom_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_sel(STRAP), .wr_busy(wr_busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] dev_byte(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  // back-end memory model with random stalls
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        wr_ready = ($urandom % 3) != 0;
        if (wr_valid && wr_ready) begin
          stg_a[stg_n] = int'(wr_addr);
          stg_d[stg_n] = wr_data;
          stg_n++;
          wr_hs++;
        end
        if (rd_valid) begin
          if (rd_wait == 0) begin
            rd_ready = 1'b1;
            rd_hs++;
          end else begin
            rd_ready = 1'b0;
            rd_wait--;
          end
        end else begin
          rd_ready = 1'b0;
          rd_wait  = $urandom % 4;
        end
        if (wr_commit) begin
          for (int k = 0; k < stg_n; k++) mem[stg_a[k]] = stg_d[k];
          stg_n = 0;
          commits++;
          busy_cnt = BUSY_CYC;
        end
        wr_busy = busy_cnt > 0;
        if (busy_cnt > 0) busy_cnt--;
      end
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; clk_wait(Q);
    scl_drv = 1'b1; clk_wait(H);
    sda_drv = 1'b0; clk_wait(H);
    scl_drv = 1'b0; clk_wait(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; clk_wait(Q);
    scl_drv = 1'b1; clk_wait(H);
    sda_drv = 1'b1; clk_wait(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; clk_wait(Q);
      scl_drv = 1'b1; clk_wait(H);
      scl_drv = 1'b0; clk_wait(Q);
    end
    sda_drv = 1'b1; clk_wait(Q);
    scl_drv = 1'b1; clk_wait(H/2);
    ack = (sda_line == 1'b0);
    clk_wait(H/2);
    scl_drv = 1'b0; clk_wait(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_wait(Q);
      scl_drv = 1'b1; clk_wait(H/2);
      b[i] = sda_line;
      clk_wait(H/2 - 1);
      if (sda_line != b[i]) unstable++;
      clk_wait(1);
      scl_drv = 1'b0; clk_wait(Q);
    end
    sda_drv = give_ack ? 1'b0 : 1'b1; clk_wait(Q);
    scl_drv = 1'b1; clk_wait(H);
    scl_drv = 1'b0; clk_wait(Q);
  endtask

  task automatic wait_idle();
    while (wr_busy) @(negedge clk);
    clk_wait(4);
  endtask

  task automatic do_write(input int a, input int n);
    logic ack;
    int hs0, cm0;
    hs0 = wr_hs; cm0 = commits;
    bus_start();
    send_byte(dev_byte(1'b0), ack); check_eq("R4 write device ack", int'(ack), 1);
    send_byte(8'(a), ack);          check_eq("R7 word address ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);      check_eq("R7 data ack", int'(ack), 1);
    end
    bus_stop();
    check_eq("R8 write handshakes", wr_hs - hs0, n);
    check_eq("R11 one commit per write", commits - cm0, 1);
    for (int k = 0; k < n; k++) model[(a + k) % MEM] = wbuf[k];
    exp_ptr = (a + n) % MEM;
    wait_idle();
  endtask

  task automatic do_read(input int a, input int n);
    logic ack;
    logic [7:0] b;
    int cm0;
    cm0 = commits;
    bus_start();
    send_byte(dev_byte(1'b0), ack); check_eq("R4 dummy write ack", int'(ack), 1);
    send_byte(8'(a), ack);          check_eq("R7 read address ack", int'(ack), 1);
    bus_start();
    send_byte(dev_byte(1'b1), ack); check_eq("R2 repeated start read ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      check_eq("R9 R10 read data", int'(b), int'(model[(a + k) % MEM]));
    end
    bus_stop();
    check_eq("R11 no commit on read", commits - cm0, 0);
    exp_ptr = (a + n) % MEM;
    clk_wait(4);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int a, n, hs0, rh0, cm0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < MEM; i++) begin
      mem[i]   = init_val(i);
      model[i] = init_val(i);
    end
    clk_wait(5);
    check_eq("R1 oe in reset", int'(sda_oe), 0);
    check_eq("R1 requests in reset", int'({wr_valid, rd_valid, wr_commit}), 0);
    rst_n = 1'b1;
    clk_wait(5);
    check_eq("R1 idle after reset", int'({sda_oe, wr_valid, rd_valid, wr_commit}), 0);

    // directed write then random read back
    for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
    do_write(16, 4);
    do_read(16, 4);

    // type code mismatch, following byte ignored
    hs0 = wr_hs; cm0 = commits;
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ack); check_eq("R5 type mismatch nack", int'(ack), 0);
    send_byte(8'h00, ack);                  check_eq("R5 R12 ignored byte nack", int'(ack), 0);
    bus_stop();
    check_eq("R5 no write request", wr_hs - hs0, 0);
    check_eq("R11 no commit after mismatch", commits - cm0, 0);

    // strap mismatch on a read
    rh0 = rd_hs;
    bus_start();
    send_byte({4'b1010, STRAP ^ 3'b010, 1'b1}, ack); check_eq("R5 strap mismatch nack", int'(ack), 0);
    recv_byte(1'b0, b); check_eq("R12 released after mismatch", int'(b), 8'hFF);
    bus_stop();
    check_eq("R5 no read request", rd_hs - rh0, 0);

    // busy: matching address not acknowledged
    wbuf[0] = 8'h3C;
    bus_start();
    send_byte(dev_byte(1'b0), ack); send_byte(8'd40, ack); send_byte(wbuf[0], ack);
    bus_stop();
    model[40] = wbuf[0];
    check_eq("R6 busy raised", int'(wr_busy), 1);
    bus_start();
    send_byte(dev_byte(1'b0), ack); check_eq("R6 no ack while busy", int'(ack), 0);
    bus_stop();
    wait_idle();
    do_read(40, 1);

    // wrap across the last location, then current-address read
    do_read(MEM - 2, 4);
    a = exp_ptr;
    bus_start();
    send_byte(dev_byte(1'b1), ack); check_eq("R4 current read ack", int'(ack), 1);
    recv_byte(1'b1, b); check_eq("R9 current addr byte 0", int'(b), int'(model[a]));
    recv_byte(1'b0, b); check_eq("R9 current addr byte 1", int'(b), int'(model[(a + 1) % MEM]));
    // after the no-acknowledge: standby, released line, no fetch
    rh0 = rd_hs;
    recv_byte(1'b0, b); check_eq("R10 R12 released after nack", int'(b), 8'hFF);
    check_eq("R10 no fetch after nack", rd_hs - rh0, 0);
    bus_stop();

    // repeated start inside a write keeps both bytes for the Stop
    cm0 = commits;
    bus_start();
    send_byte(dev_byte(1'b0), ack); send_byte(8'd90, ack); send_byte(8'hA5, ack);
    bus_start();
    send_byte(dev_byte(1'b0), ack); check_eq("R2 repeated start write ack", int'(ack), 1);
    send_byte(8'd7, ack); send_byte(8'h5A, ack);
    bus_stop();
    check_eq("R11 single commit", commits - cm0, 1);
    model[90] = 8'hA5; model[7] = 8'h5A;
    wait_idle();
    do_read(90, 1);
    do_read(7, 1);

    // constrained random writes and reads
    for (int it = 0; it < 10; it++) begin
      a = $urandom % MEM;
      n = 1 + ($urandom % 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(a, n);
      do_read(($urandom % 2) ? a : ($urandom % MEM), 1 + ($urandom % 6));
    end

    check_eq("R3 read bits stable while SCL high", unstable, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule